// File: doc/BRIEF.md
# Radix-3 Section Input Combiner

This block is the front end of a transform that builds one length-N DFT out of three DFTs of length N/3. The input record of N samples (N a multiple of three) is cut into three back-to-back sections of N/3 samples. Each accepted beat carries the sample at the same local index n from each of the three sections, together with n and a phase selector k. The block folds the three samples with the cube-root-of-unity weights for phase k. For phases 1 and 2 it then turns the folded value by exp(-j2πkn/N), so that the result can go straight into a short transform.

The two weighted terms are built from the sum and the difference of the second and third section samples. The result is a constant scale by √3/2 on the two parts of the difference, plus a halving of the sum done with a one-bit arithmetic shift. This costs two real constant multipliers in place of four complex products. A one-bit mode treats the three inputs as a real ±1 spreading code. In that mode the constant scale reduces to a conditional negation. The interface is a valid/ready stream with a fixed three-stage pipeline that freezes while the consumer is not ready.

Top module: `radix3_section_combiner`

## Requirements
- R1: After reset and until the first accepted input has crossed the pipeline, out_valid is 0.
- R2: Phase 0 (in_phase = 0) outputs, per real and imaginary part, x0 + x1 + x2 saturated to [-32768, 32767], with no rotation.
- R3: Phase 1 first forms a = x1 + x2 and d = x1 − x2. The combined value is then v_re = x0_re − a_re/2 + C·d_im and v_im = x0_im − a_im/2 − C·d_re, with C = 28378 (√3/2 in Q1.15). It is evaluated as (x0·2^15 − (a·2^15 >>> 1) ± C·d), then rounded and saturated.
- R4: Phase 2 uses the conjugate weight: v_re = x0_re − a_re/2 − C·d_im and v_im = x0_im − a_im/2 + C·d_re, with the same rounding and saturation.
- R5: For phases 1 and 2 the combined value v is multiplied by w = (wr + j·wi). Here m = k·n, wr = round(32767·cos(2πm/N)) and wi = round(−32767·sin(2πm/N)), rounding half away from zero. The result is y_re = v_re·wr − v_im·wi and y_im = v_re·wi + v_im·wr, then rounded and saturated.
- R6: Every Q15 rounding step adds 2^14 and shifts right arithmetically by 15. Every result is saturated to the 16-bit signed range.
- R7: With out_ready held at 1, a sample accepted at clock edge E is presented at the output after edge E+2, three registers in all.
- R8: in_ready equals out_ready. While out_ready is 0, out_valid and the output data hold their values, and no input is accepted or lost.
- R9: With in_code = 1, each section's real part is replaced by −1 when its bit 0 is 1 and by +1 when bit 0 is 0, and its imaginary part is ignored. The output equals the result for those values in normal mode.
- R10: in_idx ranges over 0 to N/3−1 and in_phase over 0 to 2. The largest rotation index, 2·(N/3−1), is produced correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high |
| in_phase | input | 2 | Output phase k (0, 1, 2) |
| in_idx | input | clog2(N/3) | Local sample index n |
| in_code | input | 1 | Real ±1 code mode |
| in_x0_re | input | 16 | Section 0 sample, real |
| in_x0_im | input | 16 | Section 0 sample, imaginary |
| in_x1_re | input | 16 | Section 1 sample, real |
| in_x1_im | input | 16 | Section 1 sample, imaginary |
| in_x2_re | input | 16 | Section 2 sample, real |
| in_x2_im | input | 16 | Section 2 sample, imaginary |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer ready |
| out_re | output | 16 | Result, real |
| out_im | output | 16 | Result, imaginary |

## Verification
Assertions watch on every cycle that the inputs stay legal and that a stalled output keeps its value. They also check that a phase-0 value passes the rotator unchanged, that code mode yields a zero imaginary sum, and that index 0 reads the unit twiddle. The arithmetic itself can only be shown by the bench's scenarios. These include the exact Q15 rounding of the folded and rotated values, the conjugate relation between phases 1 and 2, and saturation at both rails. The same holds for the three-cycle latency, the index at the top of the section, and the absence of lost beats across random stalls.

// File: rtl/r3c_pkg.sv
`timescale 1ns/1ps
package r3c_pkg;
    localparam int DW   = 16;              // data part width
    localparam int CW   = 16;              // coefficient width
    localparam int FRAC = CW - 1;          // Q1.15 fraction bits
    localparam int SW   = DW + 1;          // sum/difference width
    localparam int PW   = SW + CW;         // constant product width
    localparam int AW   = DW + CW + 4;     // accumulator width
    localparam int COEF_MAX = (2 ** (CW - 1)) - 1;

    localparam logic signed [CW-1:0] HALF_ROOT3 = 16'sd28378;
    localparam logic signed [AW-1:0] SAT_HI     = AW'((2 ** (DW - 1)) - 1);
    localparam logic signed [AW-1:0] SAT_LO     = -SAT_HI - 1;
    localparam logic signed [AW-1:0] ROUND_HALF = AW'(1) <<< (FRAC - 1);

    typedef logic signed [DW-1:0] dat_t;
    typedef logic signed [SW-1:0] wide_t;
    typedef logic signed [CW-1:0] coef_t;

    typedef struct packed { dat_t re;  dat_t im;  } cplx_t;
    typedef struct packed { wide_t re; wide_t im; } cplx_w_t;

    typedef enum logic [1:0] {
        PH_SUM  = 2'd0,
        PH_ROT1 = 2'd1,
        PH_ROT2 = 2'd2,
        PH_BAD  = 2'd3
    } phase_e;

    typedef struct packed {
        logic    valid;
        phase_e  phase;
        logic    code;
        cplx_t   x0;
        cplx_w_t sum;
        cplx_w_t dif;
    } fold_t;

    typedef struct packed {
        logic   valid;
        phase_e phase;
        logic   code;
        cplx_t  v;
    } comb_t;

    function automatic dat_t saturate(input logic signed [AW-1:0] v);
        if (v > SAT_HI) return dat_t'(SAT_HI[DW-1:0]);
        if (v < SAT_LO) return dat_t'(SAT_LO[DW-1:0]);
        return v[DW-1:0];
    endfunction

    function automatic logic signed [AW-1:0] round_q(input logic signed [AW-1:0] v);
        return (v + ROUND_HALF) >>> FRAC;
    endfunction

    function automatic cplx_t code_value(input cplx_t x);
        cplx_t r;
        r.re = x.re[0] ? dat_t'(-1) : dat_t'(1);
        r.im = '0;
        return r;
    endfunction

    // {re, im} of exp(-j*2*pi*m/len) in Q1.15, rounded half away from zero
    function automatic logic [2*CW-1:0] twiddle_word(input int m, input int len);
        real th, cr, sr;
        int  ci, si;
        th = 2.0 * 3.14159265358979323846 * real'(m) / real'(len);
        cr = real'(COEF_MAX) * $cos(th);
        sr = -real'(COEF_MAX) * $sin(th);
        ci = (cr >= 0.0) ? $rtoi(cr + 0.5) : $rtoi(cr - 0.5);
        si = (sr >= 0.0) ? $rtoi(sr + 0.5) : $rtoi(sr - 0.5);
        return {ci[CW-1:0], si[CW-1:0]};
    endfunction
endpackage

// File: rtl/r3c_fold.sv
`timescale 1ns/1ps
module r3c_fold
    import r3c_pkg::*;
#(
    parameter int SEC_LEN = 16,
    parameter int IW      = 4,
    parameter int TIW     = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic           in_valid,
    input  logic [1:0]     phase,
    input  logic [IW-1:0]  idx,
    input  logic           code,
    input  cplx_t          x0,
    input  cplx_t          x1,
    input  cplx_t          x2,
    output fold_t          s1,
    output logic [TIW-1:0] tw_idx
);
    cplx_t y0, y1, y2;

    always_comb begin
        y0 = code ? code_value(x0) : x0;
        y1 = code ? code_value(x1) : x1;
        y2 = code ? code_value(x2) : x2;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1     <= '0;
            tw_idx <= '0;
        end else if (en) begin
            s1.valid  <= in_valid;
            s1.phase  <= phase_e'(phase);
            s1.code   <= code;
            s1.x0     <= y0;
            s1.sum.re <= SW'(y1.re) + SW'(y2.re);
            s1.sum.im <= SW'(y1.im) + SW'(y2.im);
            s1.dif.re <= SW'(y1.re) - SW'(y2.re);
            s1.dif.im <= SW'(y1.im) - SW'(y2.im);
            case (phase)
                2'd1:    tw_idx <= TIW'(idx);
                2'd2:    tw_idx <= TIW'(idx) << 1;
                default: tw_idx <= '0;
            endcase
        end
    end

    p_legal_input_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (phase != 2'd3) && (32'(idx) < SEC_LEN))
        else $error("illegal phase or index at input");
endmodule

// File: rtl/r3c_combine.sv
`timescale 1ns/1ps
module r3c_combine
    import r3c_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  fold_t s1,
    output comb_t s2
);
    logic signed [PW-1:0] p_re, p_im;      // C*d_re, C*d_im
    logic signed [AW-1:0] base_re, base_im, acc_re, acc_im;
    cplx_t                v_next;

    always_comb begin
        if (s1.code) begin
            // d is -2, 0 or +2: the constant scale is a conditional negation
            p_im = '0;
            if (s1.dif.re == '0)   p_re = '0;
            else if (s1.dif.re[SW-1]) p_re = -(PW'(HALF_ROOT3) <<< 1);
            else                   p_re = PW'(HALF_ROOT3) <<< 1;
        end else begin
            p_re = PW'(s1.dif.re) * PW'(HALF_ROOT3);
            p_im = PW'(s1.dif.im) * PW'(HALF_ROOT3);
        end

        base_re = (AW'(s1.x0.re) <<< FRAC) - ((AW'(s1.sum.re) <<< FRAC) >>> 1);
        base_im = (AW'(s1.x0.im) <<< FRAC) - ((AW'(s1.sum.im) <<< FRAC) >>> 1);

        case (s1.phase)
            PH_ROT1: begin
                acc_re = base_re + AW'(p_im);
                acc_im = base_im - AW'(p_re);
            end
            PH_ROT2: begin
                acc_re = base_re - AW'(p_im);
                acc_im = base_im + AW'(p_re);
            end
            default: begin
                acc_re = AW'(s1.x0.re) + AW'(s1.sum.re);
                acc_im = AW'(s1.x0.im) + AW'(s1.sum.im);
            end
        endcase

        if (s1.phase == PH_ROT1 || s1.phase == PH_ROT2) begin
            v_next.re = saturate(round_q(acc_re));
            v_next.im = saturate(round_q(acc_im));
        end else begin
            v_next.re = saturate(acc_re);
            v_next.im = saturate(acc_im);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2 <= '0;
        end else if (en) begin
            s2.valid <= s1.valid;
            s2.phase <= s1.phase;
            s2.code  <= s1.code;
            s2.v     <= v_next;
        end
    end

    p_code_imag_r9: assert property (@(posedge clk) disable iff (rst)
        (en && s1.valid && s1.code && s1.phase == PH_SUM) |=> (s2.v.im == '0))
        else $error("code mode produced a nonzero imaginary sum");
endmodule

// File: rtl/r3c_twiddle_rom.sv
`timescale 1ns/1ps
module r3c_twiddle_rom
    import r3c_pkg::*;
#(
    parameter int LEN   = 48,
    parameter int DEPTH = 31,
    parameter int TIW   = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic [TIW-1:0] idx,
    output coef_t          coef_re,
    output coef_t          coef_im
);
    coef_t tab_re [DEPTH];
    coef_t tab_im [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_tab
        localparam logic [2*CW-1:0] WORD = twiddle_word(g, LEN);
        assign tab_re[g] = coef_t'(WORD[2*CW-1:CW]);
        assign tab_im[g] = coef_t'(WORD[CW-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            coef_re <= '0;
            coef_im <= '0;
        end else if (en) begin
            coef_re <= tab_re[idx];
            coef_im <= tab_im[idx];
        end
    end

    p_unit_twiddle_r5: assert property (@(posedge clk) disable iff (rst)
        (en && idx == '0) |=> (coef_re == coef_t'(COEF_MAX) && coef_im == '0))
        else $error("index 0 did not read the unit twiddle");
endmodule

// File: rtl/r3c_rotate.sv
`timescale 1ns/1ps
module r3c_rotate
    import r3c_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  comb_t s2,
    input  coef_t coef_re,
    input  coef_t coef_im,
    output logic  out_valid,
    output cplx_t y
);
    logic signed [AW-1:0] m_re, m_im;
    cplx_t                y_next;

    always_comb begin
        m_re = AW'(s2.v.re) * AW'(coef_re) - AW'(s2.v.im) * AW'(coef_im);
        m_im = AW'(s2.v.re) * AW'(coef_im) + AW'(s2.v.im) * AW'(coef_re);
        if (s2.phase == PH_SUM) begin
            y_next = s2.v;
        end else begin
            y_next.re = saturate(round_q(m_re));
            y_next.im = saturate(round_q(m_im));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            y         <= '0;
        end else if (en) begin
            out_valid <= s2.valid;
            y         <= y_next;
        end
    end

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !en) |=> (out_valid && $stable(y)))
        else $error("output changed during a stall");

    p_phase0_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (en && s2.valid && s2.phase == PH_SUM) |=> (y == $past(s2.v)))
        else $error("phase 0 value altered by the rotator");
endmodule

// File: rtl/radix3_section_combiner.sv
`timescale 1ns/1ps
module radix3_section_combiner
    import r3c_pkg::*;
#(
    parameter int N_LEN = 48
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [1:0]                   in_phase,
    input  logic [$clog2(N_LEN/3)-1:0]   in_idx,
    input  logic                         in_code,
    input  logic signed [DW-1:0]         in_x0_re,
    input  logic signed [DW-1:0]         in_x0_im,
    input  logic signed [DW-1:0]         in_x1_re,
    input  logic signed [DW-1:0]         in_x1_im,
    input  logic signed [DW-1:0]         in_x2_re,
    input  logic signed [DW-1:0]         in_x2_im,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic signed [DW-1:0]         out_re,
    output logic signed [DW-1:0]         out_im
);
    localparam int SEC_LEN  = N_LEN / 3;
    localparam int IW       = $clog2(SEC_LEN);
    localparam int TW_DEPTH = 2 * SEC_LEN - 1;   // k*n never exceeds 2*(N/3-1)
    localparam int TIW      = (TW_DEPTH > 1) ? $clog2(TW_DEPTH) : 1;

    logic           en;
    cplx_t          x0, x1, x2, y;
    fold_t          s1;
    comb_t          s2;
    logic [TIW-1:0] tw_idx;
    coef_t          coef_re, coef_im;

    assign en       = out_ready;
    assign in_ready = out_ready;
    assign x0       = '{re: in_x0_re, im: in_x0_im};
    assign x1       = '{re: in_x1_re, im: in_x1_im};
    assign x2       = '{re: in_x2_re, im: in_x2_im};
    assign out_re   = y.re;
    assign out_im   = y.im;

    r3c_fold #(.SEC_LEN(SEC_LEN), .IW(IW), .TIW(TIW)) u_fold (
        .clk(clk), .rst(rst), .en(en), .in_valid(in_valid),
        .phase(in_phase), .idx(in_idx), .code(in_code),
        .x0(x0), .x1(x1), .x2(x2), .s1(s1), .tw_idx(tw_idx)
    );

    r3c_combine u_combine (
        .clk(clk), .rst(rst), .en(en), .s1(s1), .s2(s2)
    );

    r3c_twiddle_rom #(.LEN(N_LEN), .DEPTH(TW_DEPTH), .TIW(TIW)) u_rom (
        .clk(clk), .rst(rst), .en(en), .idx(tw_idx),
        .coef_re(coef_re), .coef_im(coef_im)
    );

    r3c_rotate u_rotate (
        .clk(clk), .rst(rst), .en(en), .s2(s2),
        .coef_re(coef_re), .coef_im(coef_im),
        .out_valid(out_valid), .y(y)
    );

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid)
        else $error("output valid right after reset");
endmodule

// File: tb/radix3_section_combiner_bench.sv
`timescale 1ns/1ps
module radix3_section_combiner_bench;
    localparam int N_LEN = 48;
    localparam int SEC   = N_LEN / 3;
    localparam longint C3 = 28378;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_ready, in_code = 1'b0, out_valid, out_ready = 1'b0;
    logic [1:0] in_phase = '0;
    logic [3:0] in_idx = '0;
    logic signed [15:0] in_x0_re = '0, in_x0_im = '0, in_x1_re = '0, in_x1_im = '0;
    logic signed [15:0] in_x2_re = '0, in_x2_im = '0, out_re, out_im;

    int checks = 0, errors = 0, cyc = 0;
    bit lat_chk = 1'b0;
    int q_re[$], q_im[$], q_cyc[$];
    string q_tag[$];

    always #4 clk = ~clk;

    radix3_section_combiner #(.N_LEN(N_LEN)) u_radix3_section_combiner (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_phase(in_phase), .in_idx(in_idx), .in_code(in_code),
        .in_x0_re(in_x0_re), .in_x0_im(in_x0_im), .in_x1_re(in_x1_re),
        .in_x1_im(in_x1_im), .in_x2_re(in_x2_re), .in_x2_im(in_x2_im),
        .out_valid(out_valid), .out_ready(out_ready), .out_re(out_re), .out_im(out_im)
    );

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic longint sat16(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint rq(longint v);
        return (v + 16384) >>> 15;
    endfunction

    function automatic longint rnd_away(real v);
        return (v >= 0.0) ? longint'($rtoi(v + 0.5)) : longint'($rtoi(v - 0.5));
    endfunction

    // expected output from the requirements
    task automatic model(int k, int n, bit code, int a0r, int a0i, int a1r, int a1i,
                         int a2r, int a2i, output int yr, output int yi);
        longint x0r, x0i, x1r, x1i, x2r, x2i, ar, ai, dr, di, vr, vi, wr, wi;
        real th;
        x0r = a0r; x0i = a0i; x1r = a1r; x1i = a1i; x2r = a2r; x2i = a2i;
        if (code) begin
            x0r = a0r[0] ? -1 : 1; x1r = a1r[0] ? -1 : 1; x2r = a2r[0] ? -1 : 1;
            x0i = 0; x1i = 0; x2i = 0;
        end
        ar = x1r + x2r; ai = x1i + x2i; dr = x1r - x2r; di = x1i - x2i;
        if (k == 0) begin
            yr = int'(sat16(x0r + ar)); yi = int'(sat16(x0i + ai));
            return;
        end
        if (k == 1) begin
            vr = sat16(rq(x0r * 32768 - ar * 16384 + C3 * di));
            vi = sat16(rq(x0i * 32768 - ai * 16384 - C3 * dr));
        end else begin
            vr = sat16(rq(x0r * 32768 - ar * 16384 - C3 * di));
            vi = sat16(rq(x0i * 32768 - ai * 16384 + C3 * dr));
        end
        th = 2.0 * 3.14159265358979323846 * real'(k * n) / real'(N_LEN);
        wr = rnd_away(32767.0 * $cos(th));
        wi = rnd_away(-32767.0 * $sin(th));
        yr = int'(sat16(rq(vr * wr - vi * wi)));
        yi = int'(sat16(rq(vr * wi + vi * wr)));
    endtask

    task automatic step(bit v, int ph, int idx, bit code, int a0r, int a0i, int a1r,
                        int a1i, int a2r, int a2i, bit rdy, string tag);
        int er, ei;
        @(negedge clk);
        in_valid = v; in_phase = ph[1:0]; in_idx = idx[3:0]; in_code = code;
        in_x0_re = 16'(a0r); in_x0_im = 16'(a0i); in_x1_re = 16'(a1r);
        in_x1_im = 16'(a1i); in_x2_re = 16'(a2r); in_x2_im = 16'(a2i);
        out_ready = rdy;
        #1;
        if (out_valid && out_ready) begin
            if (q_re.size() == 0) begin
                check(1'b0, "R8", "unexpected output beat", 1, 0);
            end else begin
                int pc;
                string t;
                er = q_re.pop_front(); ei = q_im.pop_front();
                pc = q_cyc.pop_front(); t = q_tag.pop_front();
                check(out_re == 16'(er), t, "out_re", out_re, er);
                check(out_im == 16'(ei), t, "out_im", out_im, ei);
                if (lat_chk) check(cyc - pc == 3, "R7", "latency", cyc - pc, 3);
            end
        end
        if (in_valid && in_ready) begin
            model(ph, idx, code, a0r, a0i, a1r, a1i, a2r, a2i, er, ei);
            q_re.push_back(er); q_im.push_back(ei); q_cyc.push_back(cyc);
            if (tag != "") q_tag.push_back(tag);
            else if (code) q_tag.push_back("R9");
            else if (ph == 0) q_tag.push_back("R2 R6");
            else if (ph == 1) q_tag.push_back("R3 R5 R6");
            else q_tag.push_back("R4 R5 R6");
        end
        cyc++;
    endtask

    function automatic int rdata();
        int r;
        r = int'($urandom % 8);
        if (r == 0) return 32767;
        if (r == 1) return -32768;
        return int'($signed(16'($urandom)));
    endfunction

    initial begin
        #(8 * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic signed [15:0] hold_re, hold_im;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        out_ready = 1'b1;
        @(negedge clk); #1;
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(in_ready == 1'b1, "R8", "in_ready follows out_ready", in_ready, 1);

        // directed beats with a constantly ready consumer
        lat_chk = 1'b1;
        step(1, 0, 3, 0, 1, 2, 3, -4, 5, 6, 1, "R2 R7");
        step(1, 0, 0, 0, 32767, 32767, 32767, 32767, 32767, 32767, 1, "R6 high rail");
        step(1, 0, 0, 0, -32768, -32768, -32768, -32768, -32768, -32768, 1, "R6 low rail");
        step(1, 1, 0, 0, 1000, -200, 3000, 400, -500, 700, 1, "R3 R5 unit twiddle");
        step(1, 2, 0, 0, 1000, -200, 3000, 400, -500, 700, 1, "R4 conjugate");
        step(1, 1, SEC - 1, 0, 12000, -9000, 7000, 3000, -15000, 2500, 1, "R10 R3");
        step(1, 2, SEC - 1, 0, 12000, -9000, 7000, 3000, -15000, 2500, 1, "R10 R4");
        step(1, 1, 5, 1, 1, 999, 0, -777, 3, 555, 1, "R9 phase1");
        step(1, 2, 7, 1, 0, 123, 1, 456, 0, -789, 1, "R9 phase2");
        step(1, 0, 2, 1, 1, 321, 1, -321, 1, 4000, 1, "R9 phase0");
        repeat (4) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "");
        lat_chk = 1'b0;

        // stall: fill, then hold the consumer off
        step(1, 1, 4, 0, 500, 600, -700, 800, 900, -1000, 1, "R8 after stall");
        step(1, 2, 9, 0, -500, 60, 700, -80, 90, 1000, 1, "R8 after stall");
        step(1, 0, 1, 0, 11, 22, 33, 44, 55, 66, 1, "R8 after stall");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "");
        step(1, 1, 2, 0, 1, 1, 1, 1, 1, 1, 0, "R8");
        hold_re = out_re; hold_im = out_im;
        check(in_ready == 1'b0, "R8", "in_ready during stall", in_ready, 0);
        for (int s = 0; s < 4; s++) begin
            step(1, 2, 3, 0, 7, 7, 7, 7, 7, 7, 0, "R8");
            check(out_valid == 1'b1, "R8", "out_valid held", out_valid, 1);
            check(out_re == hold_re && out_im == hold_im, "R8", "data held",
                  out_re, hold_re);
        end
        repeat (4) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "");

        // constrained random traffic with random back-pressure
        for (int i = 0; i < 600; i++) begin
            bit v, rdy, cd;
            int ph;
            v   = ($urandom % 4) != 0;
            rdy = ($urandom % 5) != 0;
            cd  = ($urandom % 5) == 0;
            ph  = int'($urandom % 3);
            step(v, ph, int'($urandom % SEC), cd, rdata(), rdata(), rdata(), rdata(),
                 rdata(), rdata(), rdy, "");
        end
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "");
        check(q_re.size() == 0, "R8", "beats left undelivered", q_re.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule